// File: doc/BRIEF.md
# Compare and Status Flag Unit

This block computes the status flags produced by an 8-bit compare. It takes two register operands, an immediate operand, a 3-bit operation code, a bit index and the current status byte. A compare forms the difference of the first operand and the second (register or immediate) internally. From that difference it derives carry (borrow), zero, negative, two's-complement overflow, sign and half-carry (borrow out of bit 3). The difference itself is never written anywhere; only the status byte changes.

The compare-with-carry operation also subtracts the incoming carry. Its zero flag can only stay set, never become set, so a chain of compares can test a multi-byte quantity one byte at a time, starting with the least significant byte. Two further operations set or clear a single status bit chosen by index. The updated status byte is registered and appears one clock after the strobe.

Top module: `cmpflag_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `status_out` is 0x00.
- R2: In a cycle where `op_valid` is low, `status_out` keeps its value on the next clock edge.
- R3: Status bit layout: carry=bit0, zero=bit1, negative=bit2, overflow=bit3, sign=bit4, half-carry=bit5. For a compare, `status_out` one clock after the strobe has bit0 set exactly when the unsigned value of the subtrahend plus carry-in exceeds the unsigned minuend. Carry-in is `status_in` bit0 for compare-with-carry and 0 otherwise.
- R4: Half-carry (bit5) is set exactly when the low nibble of the subtrahend plus carry-in exceeds the low nibble of the minuend.
- R5: Overflow (bit3) is set exactly when the signed difference minuend − subtrahend − carry-in lies outside −128..127.
- R6: Negative (bit2) equals bit 7 of the 8-bit difference, and sign (bit4) equals negative XOR overflow.
- R7: For op 0 (register compare, `opnd_a` − `opnd_b`) and op 1 (immediate compare, `opnd_a` − `imm_k`), zero (bit1) is set exactly when the 8-bit difference is 0x00.
- R8: For op 2 (compare with carry, `opnd_a` − `opnd_b` − carry), zero is set only when the difference is 0x00 and `status_in` bit1 is set; otherwise it is cleared.
- R9: Op 1 ignores `opnd_b`; op 0 and op 2 ignore `imm_k`.
- R10: For ops 0, 1 and 2, bits 7 and 6 of `status_out` equal bits 7 and 6 of `status_in`.
- R11: Op 3 produces `status_in` with the bit selected by `bit_idx` (0..7) set and all other bits unchanged.
- R12: Op 4 produces `status_in` with the bit selected by `bit_idx` cleared and all other bits unchanged.
- R13: Ops 5, 6 and 7 produce `status_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Strobe: perform `op_code` this cycle |
| op_code | input | 3 | 0 reg compare, 1 immediate compare, 2 compare with carry, 3 set bit, 4 clear bit, 5-7 no change |
| opnd_a | input | 8 | Minuend register value |
| opnd_b | input | 8 | Subtrahend register value |
| imm_k | input | 8 | Immediate subtrahend |
| bit_idx | input | 3 | Status bit selected by set and clear |
| status_in | input | 8 | Current status byte |
| status_out | output | 8 | Updated status byte, registered |

## Verification
The hardest case to reach is the sticky zero of compare-with-carry. It needs a zero difference produced only by the carry-in, arriving together with an incoming zero that is either set or clear. The bench builds these from chosen operand pairs such as 0x05 − 0x04 − 1, and it runs two-byte compares by feeding each byte's output status into the next byte's `status_in`. Signed overflow at the 0x80/0x7F boundaries and nibble borrows are also driven directly, and an exhaustive sweep over a grid of operand values checks every compare flag against a model in the bench that works on signed and unsigned integers.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned IW = 3;

  typedef enum logic [IW-1:0] {
    OP_CMP_REG = 3'd0,
    OP_CMP_IMM = 3'd1,
    OP_CMP_CRY = 3'd2,
    OP_BIT_SET = 3'd3,
    OP_BIT_CLR = 3'd4
  } op_e;

  localparam int unsigned B_C = 0;
  localparam int unsigned B_Z = 1;
  localparam int unsigned B_N = 2;
  localparam int unsigned B_V = 3;
  localparam int unsigned B_S = 4;
  localparam int unsigned B_H = 5;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  // borrow term for every bit position of a subtraction
  function automatic logic [DW-1:0] borrow_vec(input logic [DW-1:0] m,
                                               input logic [DW-1:0] sb,
                                               input logic [DW-1:0] d);
    return (~m & sb) | (sb & d) | (d & ~m);
  endfunction

  function automatic logic ovf_bit(input logic [DW-1:0] m,
                                   input logic [DW-1:0] sb,
                                   input logic [DW-1:0] d);
    return (m[DW-1] & ~sb[DW-1] & ~d[DW-1]) | (~m[DW-1] & sb[DW-1] & d[DW-1]);
  endfunction

  function automatic flags_t cmp_flags(input logic [DW-1:0] m,
                                       input logic [DW-1:0] sb,
                                       input logic cin,
                                       input logic zin,
                                       input logic sticky);
    flags_t f;
    logic [DW-1:0] d;
    logic [DW-1:0] bv;
    d   = m - sb - {{(DW-1){1'b0}}, cin};
    bv  = borrow_vec(m, sb, d);
    f.c = bv[DW-1];
    f.h = bv[3];
    f.v = ovf_bit(m, sb, d);
    f.n = d[DW-1];
    f.s = f.n ^ f.v;
    f.z = (d == '0) && (!sticky || zin);
    return f;
  endfunction
endpackage

// File: rtl/cmpflag_arith.sv
module cmpflag_arith
  import cmpflag_pkg::*;
(
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtr,
  input  logic          carry_en,
  input  logic [DW-1:0] status_cur,
  output logic [DW-1:0] status_cmp
);
  flags_t f;
  logic   cin;

  assign cin = carry_en & status_cur[B_C];

  always_comb begin
    f = cmp_flags(minuend, subtr, cin, status_cur[B_Z], carry_en);
    status_cmp        = status_cur;
    status_cmp[B_C]   = f.c;
    status_cmp[B_Z]   = f.z;
    status_cmp[B_N]   = f.n;
    status_cmp[B_V]   = f.v;
    status_cmp[B_S]   = f.s;
    status_cmp[B_H]   = f.h;
  end
endmodule

// File: rtl/cmpflag_bitop.sv
module cmpflag_bitop
  import cmpflag_pkg::*;
(
  input  logic [IW-1:0] idx,
  input  logic          set_not_clr,
  input  logic [DW-1:0] status_cur,
  output logic [DW-1:0] status_bit
);
  logic [DW-1:0] sel;

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign sel[g]        = (idx == IW'(g));
    assign status_bit[g] = sel[g] ? set_not_clr : status_cur[g];
  end
endmodule

// File: rtl/cmpflag_unit.sv
module cmpflag_unit
  import cmpflag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [7:0]    opnd_a,
  input  logic [7:0]    opnd_b,
  input  logic [7:0]    imm_k,
  input  logic [2:0]    bit_idx,
  input  logic [7:0]    status_in,
  output logic [7:0]    status_out
);
  logic          is_cmp, is_cry, is_set, is_clr, is_bit;
  logic [DW-1:0] subtr;
  logic [DW-1:0] status_cmp;
  logic [DW-1:0] status_bit;
  logic [DW-1:0] status_nxt;

  assign is_cry = (op_code == OP_CMP_CRY);
  assign is_cmp = (op_code == OP_CMP_REG) || (op_code == OP_CMP_IMM) || is_cry;
  assign is_set = (op_code == OP_BIT_SET);
  assign is_clr = (op_code == OP_BIT_CLR);
  assign is_bit = is_set || is_clr;
  assign subtr  = (op_code == OP_CMP_IMM) ? imm_k : opnd_b;

  cmpflag_arith u_arith (
    .minuend   (opnd_a),
    .subtr     (subtr),
    .carry_en  (is_cry),
    .status_cur(status_in),
    .status_cmp(status_cmp)
  );

  cmpflag_bitop u_bitop (
    .idx        (bit_idx),
    .set_not_clr(is_set),
    .status_cur (status_in),
    .status_bit (status_bit)
  );

  always_comb begin
    if (is_cmp)      status_nxt = status_cmp;
    else if (is_bit) status_nxt = status_bit;
    else             status_nxt = status_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        status_out <= '0;
    else if (op_valid) status_out <= status_nxt;
  end

  // R2: no strobe, no change
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_out));

  // R6: sign follows negative and overflow
  a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |=> (status_out[B_S] == (status_out[B_N] ^ status_out[B_V])));

  // R10: upper bits pass through compares
  a_r10_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cmp) |=> (status_out[7:6] == $past(status_in[7:6])));

  // R8: sticky zero never turns on
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_cry && !status_in[B_Z]) |=> !status_out[B_Z]);

  // R11: selected bit ends up set
  a_r11_set: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_set) |=> status_out[$past(bit_idx)]);

  // R12: selected bit ends up clear
  a_r12_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && is_clr) |=> !status_out[$past(bit_idx)]);

  // R13: undefined codes pass the status through
  a_r13_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_cmp && !is_bit) |=> (status_out == $past(status_in)));
endmodule

// File: tb/cmpflag_unit_tb_top.sv
module cmpflag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, imm_k = '0, status_in = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] status_out;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmpflag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_k(imm_k), .bit_idx(bit_idx),
    .status_in(status_in), .status_out(status_out)
  );

  // integer model of a compare
  function automatic logic [7:0] model_cmp(input int a, input int b, input int cin,
                                           input logic [7:0] sin, input bit sticky);
    logic [7:0] r;
    int ud, sd, sa, sb, low;
    logic n, v;
    ud  = a - b - cin;
    low = (a % 16) - (b % 16) - cin;
    sa  = (a > 127) ? a - 256 : a;
    sb  = (b > 127) ? b - 256 : b;
    sd  = sa - sb - cin;
    r   = sin;
    n   = ((ud + 256) % 256) >= 128;
    v   = (sd < -128) || (sd > 127);
    r[0] = ud < 0;
    r[1] = (((ud + 256) % 256) == 0) && (!sticky || sin[1]);
    r[2] = n;
    r[3] = v;
    r[4] = n ^ v;
    r[5] = low < 0;
    return r;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] k, input logic [2:0] idx, input logic [7:0] sin);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; imm_k = k;
    bit_idx = idx; status_in = sin;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", status_out, 8'h00);
  endtask

  task automatic t_cmp_cases();
    issue(3'd0, 8'h42, 8'h42, 8'h00, 3'd0, 8'hC0);
    check("R7 equal", status_out, 8'hC2);
    issue(3'd0, 8'h10, 8'h01, 8'h00, 3'd0, 8'h00);
    check("R4 nibble borrow", status_out, 8'h20);
    issue(3'd0, 8'h01, 8'h02, 8'h00, 3'd0, 8'h00);
    check("R3 borrow", status_out, 8'h35);
    issue(3'd0, 8'h80, 8'h01, 8'h00, 3'd0, 8'h00);
    check("R5 neg overflow", status_out, 8'h38);
    issue(3'd0, 8'h7F, 8'hFF, 8'h00, 3'd0, 8'h00);
    check("R5 pos overflow", status_out, 8'h0D);
    issue(3'd0, 8'h90, 8'h10, 8'h00, 3'd0, 8'h40);
    check("R6 negative", status_out, 8'h54);
  endtask

  task automatic t_imm();
    issue(3'd1, 8'h33, 8'h00, 8'h33, 3'd0, 8'h00);
    check("R9 imm used", status_out, 8'h02);
    issue(3'd0, 8'h33, 8'h33, 8'h99, 3'd0, 8'h00);
    check("R9 imm ignored", status_out, 8'h02);
  endtask

  task automatic t_carry();
    issue(3'd2, 8'h05, 8'h04, 8'h00, 3'd0, 8'h03);
    check("R8 zero kept", status_out, 8'h02);
    issue(3'd2, 8'h05, 8'h04, 8'h00, 3'd0, 8'h01);
    check("R8 zero not raised", status_out, 8'h00);
    issue(3'd2, 8'h05, 8'h04, 8'h00, 3'd0, 8'h02);
    check("R8 nonzero clears", status_out, 8'h00);
    issue(3'd2, 8'h00, 8'h00, 8'h00, 3'd0, 8'h03);
    check("R3 carry-in borrow", status_out, 8'h35);
  endtask

  task automatic t_multibyte();
    logic [7:0] s;
    // 0x1234 vs 0x1234: equal
    issue(3'd0, 8'h34, 8'h34, 8'h00, 3'd0, 8'h00);
    s = status_out;
    issue(3'd2, 8'h12, 8'h12, 8'h00, 3'd0, s);
    check("R8 16-bit equal", status_out, 8'h02);
    // 0x1200 vs 0x11FF: greater, not equal
    issue(3'd0, 8'h00, 8'hFF, 8'h00, 3'd0, 8'h00);
    s = status_out;
    issue(3'd2, 8'h12, 8'h11, 8'h00, 3'd0, s);
    check("R8 16-bit greater", status_out, 8'h00);
  endtask

  task automatic t_bits();
    issue(3'd3, 8'h00, 8'h00, 8'h00, 3'd5, 8'h01);
    check("R11 set bit5", status_out, 8'h21);
    issue(3'd3, 8'h00, 8'h00, 8'h00, 3'd7, 8'h00);
    check("R11 set bit7", status_out, 8'h80);
    issue(3'd4, 8'h00, 8'h00, 8'h00, 3'd0, 8'hFF);
    check("R12 clear bit0", status_out, 8'hFE);
    issue(3'd4, 8'h00, 8'h00, 8'h00, 3'd6, 8'h40);
    check("R12 clear bit6", status_out, 8'h00);
  endtask

  task automatic t_misc();
    for (int o = 5; o < 8; o++) begin
      issue(3'(o), 8'h01, 8'h02, 8'h03, 3'd1, 8'hA5);
      check("R13 pass", status_out, 8'hA5);
    end
    @(negedge clk);
    opnd_a = 8'h00; opnd_b = 8'h01; op_code = 3'd0; status_in = 8'h3C;
    @(negedge clk);
    check("R2 hold", status_out, 8'hA5);
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 15) begin
        for (int c = 0; c < 4; c++) begin
          logic [7:0] sin;
          sin = {2'(c), 4'h0, 2'(c)};
          issue(3'd2, 8'(a), 8'(b), 8'h00, 3'd0, sin);
          check("R3 R4 R5 R8 R10 sweep cpc", status_out, model_cmp(a, b, c % 2, sin, 1'b1));
        end
        issue(3'd0, 8'(a), 8'(b), 8'h00, 3'd0, 8'h80);
        check("R3 R5 R6 R7 sweep cp", status_out, model_cmp(a, b, 0, 8'h80, 1'b0));
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", status_out, 8'h00);
    t_cmp_cases();
    t_imm();
    t_carry();
    t_multibyte();
    t_bits();
    t_misc();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule